// File: doc/BRIEF.md
# RTC Update Cycle Sequencer

This block paces the once-per-second refresh of a real-time clock. A prescaler counts enable pulses from a 32.768 kHz timebase. Shortly before each one-second boundary the block raises an update-in-progress flag (UIP). On the boundary it sends a single-cycle strobe that tells the calendar counters to step. A fixed number of timebase ticks later it lowers UIP and pulses an update-complete strobe. The calendar counters are not part of this block.

UIP goes high a set lead time before the counters move. Software can therefore read UIP, and if it is low, read the time registers without a lock: the counters cannot change during that lead window. A three-bit divider-select field picks the prescaler mode. One code runs the prescaler. Two codes hold it in reset, and the first update then comes half a second after the hold is released. All other codes freeze the prescaler where it is. A set-mode input stops new update cycles from starting. A cycle that has already started still runs to its end. A host read strobe captures the current UIP value into a read register.

Top module: `rtc_update_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `uip`, `adv_stb`, `done_stb` and `rd_uip` are 0.
- R2: With `div_sel` = 3'b010 and `tb_tick` high, `adv_stb` pulses exactly once every `TICKS_PER_SEC` ticks.
- R3: `uip` rises exactly `LEAD_TICKS` run ticks before the cycle in which `adv_stb` is high.
- R4: `uip` falls exactly `BUSY_TICKS` run ticks after `adv_stb`. `done_stb` is high in exactly the cycle in which `uip` first reads 0.
- R5: `adv_stb` and `done_stb` are each one clock cycle wide. `adv_stb` is only ever high while `uip` is high.
- R6: `div_sel` values 3'b110 and 3'b111 clear `uip` in the next cycle without a `done_stb`. After such a hold is released into 3'b010, the first `adv_stb` comes `TICKS_PER_SEC/2` ticks later.
- R7: Any other `div_sel` value, or `tb_tick` low, freezes the block. `uip` keeps its value and no strobe is issued. Counting then resumes from the frozen point.
- R8: If `set_mode` is 1 at the tick where a cycle would start, that cycle does not start: `uip` stays 0 and `adv_stb` is not issued.
- R9: Setting `set_mode` to 1 after `uip` has risen lets that cycle finish with its `adv_stb` and `done_stb`.
- R10: In the cycle after `stat_rd` is high, `rd_uip` equals the `uip` value from the cycle of the read. Otherwise `rd_uip` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_tick | input | 1 | One-cycle enable per 32.768 kHz timebase period |
| div_sel | input | 3 | Divider select: 010 run, 110/111 hold in reset, others freeze |
| set_mode | input | 1 | Blocks new update cycles while 1 |
| stat_rd | input | 1 | Host read strobe of the status register |
| uip | output | 1 | Update-in-progress flag |
| adv_stb | output | 1 | One-cycle strobe that advances the calendar counters |
| done_stb | output | 1 | One-cycle update-complete strobe |
| rd_uip | output | 1 | UIP value captured by the last host read |

## Verification
The assertions check several properties on every clock cycle. Strobes must be single pulses, `adv_stb` must only appear inside a UIP window, and `done_stb` must coincide with the fall of UIP. A hold code must clear UIP, a freeze must leave UIP unchanged, a UIP rise must never follow a set-mode sample of 1, and a read must capture UIP. Tick counters in the checker also measure the lead and busy windows. Some behaviour only the bench scenarios can show: the half-second delay after a hold, the full one-second period, resuming from a frozen count, and a cycle finishing after set-mode is raised mid-cycle.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;

    // Prescaler operating mode decoded from the divider-select field
    typedef enum logic [1:0] {
        DM_RUN    = 2'd0,
        DM_HOLD   = 2'd1,
        DM_FREEZE = 2'd2
    } div_mode_e;

    // Update sequence phase
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_BUSY = 2'd2
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       adv;
        logic       done;
    } seq_regs_t;

endpackage

// File: rtl/rtc_seq_mode_dec.sv
module rtc_seq_mode_dec
    import rtc_seq_pkg::*;
#(
    parameter logic [2:0] RUN_CODE = 3'b010
) (
    input  logic [2:0] div_sel,
    input  logic       tb_tick,
    output div_mode_e  mode,
    output logic       run_tick
);

    // Both codes with the two upper bits set hold the chain in reset
    always_comb begin
        if (div_sel[2:1] == 2'b11) begin
            mode = DM_HOLD;
        end else if (div_sel == RUN_CODE) begin
            mode = DM_RUN;
        end else begin
            mode = DM_FREEZE;
        end
        run_tick = tb_tick && (mode == DM_RUN);
    end

endmodule

// File: rtl/rtc_seq_prescaler.sv
module rtc_seq_prescaler
    import rtc_seq_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int LEAD_TICKS    = 8,
    parameter int BUSY_TICKS    = 65
) (
    input  logic      clk,
    input  logic      rst_n,
    input  div_mode_e mode,
    input  logic      run_tick,
    output logic      lead_ev,
    output logic      wrap_ev,
    output logic      busy_ev
);

    localparam int CW = $clog2(TICKS_PER_SEC);
    localparam logic [CW-1:0] LAST_C = CW'(TICKS_PER_SEC - 1);
    localparam logic [CW-1:0] HALF_C = CW'(TICKS_PER_SEC / 2);
    localparam logic [CW-1:0] LEAD_C = CW'(TICKS_PER_SEC - 1 - LEAD_TICKS);
    localparam logic [CW-1:0] BUSY_C = CW'(BUSY_TICKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_regs_t;

    pre_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (mode == DM_HOLD) begin
            // preload so the first wrap lands half a second after release
            r_d.cnt = HALF_C;
        end else if (run_tick) begin
            r_d.cnt = (r_q.cnt == LAST_C) ? '0 : r_q.cnt + 1'b1;
        end
        lead_ev = run_tick && (r_q.cnt == LEAD_C);
        wrap_ev = run_tick && (r_q.cnt == LAST_C);
        busy_ev = run_tick && (r_q.cnt == BUSY_C);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/rtc_seq_fsm.sv
module rtc_seq_fsm
    import rtc_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  div_mode_e mode,
    input  logic      set_mode,
    input  logic      lead_ev,
    input  logic      wrap_ev,
    input  logic      busy_ev,
    output logic      uip,
    output logic      adv_stb,
    output logic      done_stb
);

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.adv  = 1'b0;
        r_d.done = 1'b0;
        if (mode == DM_HOLD) begin
            r_d.state = ST_IDLE;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    // set mode only blocks the start of a cycle
                    if (lead_ev && !set_mode) begin
                        r_d.state = ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (wrap_ev) begin
                        r_d.state = ST_BUSY;
                        r_d.adv   = 1'b1;
                    end
                end
                ST_BUSY: begin
                    if (busy_ev) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                    end
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, adv: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign uip      = (r_q.state != ST_IDLE);
    assign adv_stb  = r_q.adv;
    assign done_stb = r_q.done;

endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq
    import rtc_seq_pkg::*;
#(
    parameter int         TICKS_PER_SEC = 32768,
    parameter int         LEAD_TICKS    = 8,
    parameter int         BUSY_TICKS    = 65,
    parameter logic [2:0] RUN_CODE      = 3'b010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tb_tick,
    input  logic [2:0] div_sel,
    input  logic       set_mode,
    input  logic       stat_rd,
    output logic       uip,
    output logic       adv_stb,
    output logic       done_stb,
    output logic       rd_uip
);

    div_mode_e mode;
    logic      run_tick;
    logic      lead_ev, wrap_ev, busy_ev;
    logic      rd_uip_d, rd_uip_q;

    rtc_seq_mode_dec #(
        .RUN_CODE (RUN_CODE)
    ) u_dec (
        .div_sel  (div_sel),
        .tb_tick  (tb_tick),
        .mode     (mode),
        .run_tick (run_tick)
    );

    rtc_seq_prescaler #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .LEAD_TICKS    (LEAD_TICKS),
        .BUSY_TICKS    (BUSY_TICKS)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .run_tick (run_tick),
        .lead_ev  (lead_ev),
        .wrap_ev  (wrap_ev),
        .busy_ev  (busy_ev)
    );

    rtc_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .set_mode (set_mode),
        .lead_ev  (lead_ev),
        .wrap_ev  (wrap_ev),
        .busy_ev  (busy_ev),
        .uip      (uip),
        .adv_stb  (adv_stb),
        .done_stb (done_stb)
    );

    // Host read snapshot of the flag
    always_comb begin
        rd_uip_d = stat_rd ? uip : rd_uip_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_uip_q <= 1'b0;
        end else begin
            rd_uip_q <= rd_uip_d;
        end
    end

    assign rd_uip = rd_uip_q;

endmodule

// File: rtl/rtc_update_seq_chk.sv
module rtc_update_seq_chk #(
    parameter int         LEAD_TICKS = 8,
    parameter int         BUSY_TICKS = 65,
    parameter logic [2:0] RUN_CODE   = 3'b010
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tb_tick,
    input logic [2:0] div_sel,
    input logic       set_mode,
    input logic       stat_rd,
    input logic       uip,
    input logic       adv_stb,
    input logic       done_stb,
    input logic       rd_uip
);

    logic        run_t;
    logic        hold_c;
    logic        stall_c;
    logic [31:0] lead_cnt;
    logic [31:0] busy_cnt;
    logic        seen_adv;

    assign run_t   = tb_tick && (div_sel == RUN_CODE);
    assign hold_c  = (div_sel[2:1] == 2'b11);
    assign stall_c = !hold_c && (!tb_tick || (div_sel != RUN_CODE));

    // Window counters measured in run ticks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lead_cnt <= '0;
            busy_cnt <= '0;
            seen_adv <= 1'b0;
        end else if (!uip) begin
            lead_cnt <= '0;
            busy_cnt <= '0;
            seen_adv <= 1'b0;
        end else begin
            if (adv_stb) seen_adv <= 1'b1;
            if (run_t && !adv_stb && !seen_adv) lead_cnt <= lead_cnt + 1;
            if (run_t && (adv_stb || seen_adv)) busy_cnt <= busy_cnt + 1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !uip && !adv_stb && !done_stb && !rd_uip);

    p_adv_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        adv_stb |=> !adv_stb);

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_stb |=> !done_stb);

    p_adv_in_uip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        adv_stb |-> uip);

    p_done_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_stb |-> $fell(uip));

    p_lead_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adv_stb |-> (lead_cnt == LEAD_TICKS));

    p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_stb |-> (busy_cnt == BUSY_TICKS));

    p_hold_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_c |=> !uip && !done_stb);

    p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_c |=> $stable(uip) && !adv_stb && !done_stb);

    p_set_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uip) |-> !$past(set_mode));

    p_rd_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (rd_uip == $past(uip)));

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> $stable(rd_uip));

endmodule

bind rtc_update_seq rtc_update_seq_chk #(
    .LEAD_TICKS (LEAD_TICKS),
    .BUSY_TICKS (BUSY_TICKS),
    .RUN_CODE   (RUN_CODE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tb_tick  (tb_tick),
    .div_sel  (div_sel),
    .set_mode (set_mode),
    .stat_rd  (stat_rd),
    .uip      (uip),
    .adv_stb  (adv_stb),
    .done_stb (done_stb),
    .rd_uip   (rd_uip)
);

// File: tb/rtc_update_seq_test.sv
module rtc_update_seq_test;

    localparam int         TPS  = 256;
    localparam int         LEAD = 8;
    localparam int         BUSY = 65;
    localparam int         HALF = TPS / 2;
    localparam logic [2:0] RUN  = 3'b010;
    localparam logic [2:0] HOLD = 3'b110;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tb_tick;
    logic [2:0] div_sel;
    logic       set_mode;
    logic       stat_rd;
    logic       uip, adv_stb, done_stb, rd_uip;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // watch() statistics
    int rise_n, fall_n, adv1, adv2, done_n;
    int adv_cnt, done_cnt, uip_cnt, dbl, adv_out;

    always #2 clk = ~clk;

    rtc_update_seq #(
        .TICKS_PER_SEC (TPS),
        .LEAD_TICKS    (LEAD),
        .BUSY_TICKS    (BUSY),
        .RUN_CODE      (RUN)
    ) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tb_tick  (tb_tick),
        .div_sel  (div_sel),
        .set_mode (set_mode),
        .stat_rd  (stat_rd),
        .uip      (uip),
        .adv_stb  (adv_stb),
        .done_stb (done_stb),
        .rd_uip   (rd_uip)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Hold the divider, then release it at a falling edge
    task automatic resync();
        @(negedge clk);
        div_sel  = HOLD;
        set_mode = 1'b0;
        tb_tick  = 1'b1;
        stat_rd  = 1'b0;
        repeat (4) @(negedge clk);
        div_sel = RUN;
    endtask

    // Observe ncyc falling edges, numbered from 1
    task automatic watch(input int ncyc);
        logic pu, pa, pd;
        rise_n = -1; fall_n = -1; adv1 = -1; adv2 = -1; done_n = -1;
        adv_cnt = 0; done_cnt = 0; uip_cnt = 0; dbl = 0; adv_out = 0;
        pu = uip; pa = adv_stb; pd = done_stb;
        for (int n = 1; n <= ncyc; n++) begin
            @(negedge clk);
            if (uip && !pu && rise_n < 0) rise_n = n;
            if (!uip && pu && fall_n < 0) fall_n = n;
            if (adv_stb) begin
                if (adv_cnt == 0) adv1 = n;
                else if (adv_cnt == 1) adv2 = n;
                adv_cnt++;
                if (pa) dbl++;
                if (!uip) adv_out++;
            end
            if (done_stb) begin
                if (done_cnt == 0) done_n = n;
                done_cnt++;
                if (pd) dbl++;
            end
            if (uip) uip_cnt++;
            pu = uip; pa = adv_stb; pd = done_stb;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 uip in reset", uip, 0);
        chk("R1 strobes in reset", adv_stb | done_stb, 0);
        chk("R1 rd_uip in reset", rd_uip, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs after reset", uip | adv_stb | done_stb | rd_uip, 0);
    endtask

    task automatic t_first_update();
        resync();
        watch(400);
        chk("R6 first advance after half second", adv1, HALF);
        chk("R3 lead before advance", adv1 - rise_n, LEAD);
        chk("R4 busy after advance", fall_n - adv1, BUSY);
        chk("R4 done on uip fall", done_n, fall_n);
        chk("R2 one second period", adv2 - adv1, TPS);
        chk("R2 advance count", adv_cnt, 2);
        chk("R5 single-cycle strobes", dbl, 0);
        chk("R5 advance inside uip", adv_out, 0);
    endtask

    task automatic t_set_block();
        resync();
        set_mode = 1'b1;
        watch(400);
        chk("R8 uip stays low in set mode", uip_cnt, 0);
        chk("R8 no advance in set mode", adv_cnt, 0);
        chk("R8 no done in set mode", done_cnt, 0);
    endtask

    task automatic t_set_mid();
        resync();
        watch(124);
        chk("R9 uip high before set", uip, 1);
        set_mode = 1'b1;
        watch(276);
        chk("R9 advance still issued", adv1, HALF - 124);
        chk("R9 done still issued", done_n, HALF + BUSY - 124);
        chk("R9 later cycles blocked", adv_cnt, 1);
        set_mode = 1'b0;
    endtask

    task automatic t_hold_mid();
        resync();
        watch(150);
        chk("R6 in busy window", uip, 1);
        div_sel = 3'b111;
        watch(1);
        chk("R6 hold clears uip", uip, 0);
        chk("R6 hold gives no done", done_cnt, 0);
        watch(20);
        chk("R6 stays idle in hold", uip_cnt + done_cnt + adv_cnt, 0);
    endtask

    task automatic t_freeze();
        resync();
        watch(50);
        div_sel = 3'b000;
        watch(300);
        chk("R7 code 000 freezes", uip_cnt + adv_cnt, 0);
        div_sel = 3'b011;
        watch(50);
        chk("R7 code 011 freezes", uip_cnt + adv_cnt, 0);
        div_sel = RUN;
        watch(100);
        chk("R7 resumes from frozen count", adv1, TPS - 1 - (HALF + 50) + 1);
    endtask

    task automatic t_tick_low();
        resync();
        watch(150);
        tb_tick = 1'b0;
        watch(300);
        chk("R7 uip held with tick low", uip_cnt, 300);
        chk("R7 no done with tick low", done_cnt, 0);
        tb_tick = 1'b1;
        watch(60);
        chk("R7 busy resumes where it stopped", done_n, BUSY - (150 - HALF));
    endtask

    task automatic t_read();
        resync();
        watch(125);
        stat_rd = 1'b1;
        watch(1);
        stat_rd = 1'b0;
        chk("R10 read captures uip high", rd_uip, 1);
        watch(100);
        chk("R10 uip has fallen", uip, 0);
        chk("R10 snapshot held without read", rd_uip, 1);
        stat_rd = 1'b1;
        watch(1);
        stat_rd = 1'b0;
        chk("R10 read captures uip low", rd_uip, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        tb_tick  = 1'b1;
        div_sel  = HOLD;
        set_mode = 1'b0;
        stat_rd  = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_first_update();
        t_set_block();
        t_set_mid();
        t_hold_mid();
        t_freeze();
        t_tick_low();
        t_read();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule